// File: doc/BRIEF.md
# Sector-Constant Linear Track Fitter

This block turns the full-resolution hit coordinates of one candidate track into helix parameters and a fit-quality verdict. The fit is linearised: every output row is a signed dot product of the coordinate vector with a row of constants, plus a row offset. The constant set is chosen by the detector sector the candidate belongs to. The first rows give the track parameters. The remaining rows give constraint residuals, which are squared and summed into a chi-square. A candidate passes when its chi-square is below the per-degree-of-freedom cut times the number of constraints.

The datapath is a three-register pipeline that accepts a new candidate on every clock. A per-coordinate hit mask lets a fit leave out coordinates, for example those of a missing layer, without a second constant set. A tag supplied with each candidate comes out beside its result. The constant tables are filled through a plain word-write port.

Top module: `linear_track_fitter`

## Requirements
- R1: While rst_n is low, and on every edge after reset until the first accepted candidate has crossed the pipeline, out_valid is 0.
- R2: Output row r (0..N_PAR-1) equals b_r plus the sum over coordinates j of a_rj*x_j, in signed full precision. It appears on out_par bits [r*ACC_W +: ACC_W], where ACC_W = COORD_W+CONST_W+clog2(N_COORD+1), which is 20 by default.
- R3: out_chi2 is the unsigned sum of the squares of rows N_PAR..N_PAR+N_CON-1, computed in the same way as the rows of R2.
- R4: out_pass is 1 exactly when out_chi2 < CHI_CUT*N_CON. With the defaults 4 and 9 the limit is 36, so a chi-square of 35 passes and 36 fails.
- R5: A fit uses only the constants of the sector given on in_sector in the same cycle as in_valid.
- R6: A coordinate whose in_mask bit is 0 adds nothing to any row. Bit j = 1 means coordinate j is present. With all bits 0, every row equals its offset.
- R7: A candidate sampled on the rising edge where in_valid is 1 produces out_valid = 1 after exactly the third rising edge that counts from and includes the sampling edge. Candidates may arrive on consecutive cycles, and each one produces exactly one result.
- R8: out_tag carries the in_tag of the candidate whose result is being shown.
- R9: When cfg_we is 1, cfg_data is written for sector cfg_sector and row cfg_row (0..N_PAR+N_CON-1). cfg_col 0..N_COORD-1 selects the coefficient of that coordinate, and cfg_col = N_COORD selects the row offset. Fits sampled after the write use the new value.
- R10: Coordinates and constants at their most negative or most positive codes give exact results, with no wrap in any row or in the chi-square.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the valid pipeline |
| in_valid | input | 1 | Candidate present |
| in_coord | input | N_COORD*COORD_W | Signed coordinates; coordinate j is at [j*COORD_W +: COORD_W] |
| in_mask | input | N_COORD | Presence bit for each coordinate |
| in_sector | input | clog2(N_SECT) | Sector whose constants are used |
| in_tag | input | TAG_W | Road or combination identifier |
| cfg_we | input | 1 | Constant write strobe |
| cfg_sector | input | clog2(N_SECT) | Sector of the write |
| cfg_row | input | clog2(N_PAR+N_CON) | Output row of the write |
| cfg_col | input | clog2(N_COORD+1) | Coefficient index, or N_COORD for the offset |
| cfg_data | input | CONST_W | Signed constant |
| out_valid | output | 1 | Result present |
| out_tag | output | TAG_W | Tag of the result |
| out_par | output | N_PAR*ACC_W | Signed track parameters |
| out_chi2 | output | 2*ACC_W+clog2(N_CON) | Chi-square |
| out_pass | output | 1 | Chi-square below the cut |

## Verification
The sweep over sectors and single coordinates drives a 1 into each coordinate alone. A swapped row, column or sector index then shows up at once as a wrong parameter. The chi-square cut is probed at 35 and 36, with negative residuals included, so an inclusive comparison or a dropped sign gives the wrong verdict. The all-extreme cases fill every coefficient and coordinate with -128 or 127, which exposes an accumulator or square that is one bit too narrow. Masked and back-to-back random streams would catch a mask that is not applied or a tag or valid that slips by a cycle.

// File: rtl/ltf_pkg.sv
package ltf_pkg;

   // Width of one signed row: product width plus growth for all summed terms.
   function automatic int row_width(int coord_w, int const_w, int n_terms);
      return coord_w + const_w + $clog2(n_terms);
   endfunction

   // Width of the chi-square: one square plus growth for the constraint count.
   function automatic int chi_width(int row_w, int n_con);
      return 2 * row_w + $clog2(n_con);
   endfunction

endpackage

// File: rtl/ltf_const_store.sv
module ltf_const_store #(
   parameter int N_SECT  = 4,
   parameter int N_OUT   = 14,
   parameter int N_COL   = 15,
   parameter int CONST_W = 8,
   parameter int SECT_W  = 2,
   parameter int ROW_W   = 4,
   parameter int COL_W   = 4
) (
   input  logic                             clk,
   input  logic                             wr_en,
   input  logic [SECT_W-1:0]                wr_sector,
   input  logic [ROW_W-1:0]                 wr_row,
   input  logic [COL_W-1:0]                 wr_col,
   input  logic [CONST_W-1:0]               wr_data,
   input  logic [SECT_W-1:0]                rd_sector,
   output logic [N_OUT*N_COL*CONST_W-1:0]   rd_table
);

   logic [CONST_W-1:0] mem [N_SECT][N_OUT][N_COL];
   logic               wr_in_range;

   assign wr_in_range = ({1'b0, wr_sector} < (SECT_W+1)'(N_SECT)) &&
                        ({1'b0, wr_row}    < (ROW_W+1)'(N_OUT))   &&
                        ({1'b0, wr_col}    < (COL_W+1)'(N_COL));

   always_ff @(posedge clk) begin
      if (wr_en && wr_in_range)
         mem[wr_sector][wr_row][wr_col] <= wr_data;
   end

   for (genvar r = 0; r < N_OUT; r++) begin : g_row
      for (genvar c = 0; c < N_COL; c++) begin : g_col
         assign rd_table[(r*N_COL + c)*CONST_W +: CONST_W] = mem[rd_sector][r][c];
      end
   end

endmodule

// File: rtl/ltf_dot_row.sv
module ltf_dot_row #(
   parameter int N_COORD = 14,
   parameter int COORD_W = 8,
   parameter int CONST_W = 8,
   parameter int ACC_W   = 20
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          vld,
   input  logic [N_COORD*COORD_W-1:0]    coords,
   input  logic [N_COORD-1:0]            mask,
   input  logic [N_COORD*CONST_W-1:0]    coefs,
   input  logic [CONST_W-1:0]            offset,
   output logic signed [ACC_W-1:0]       acc_q
);

   logic signed [ACC_W-1:0] off_ext;
   logic signed [ACC_W-1:0] term;
   logic signed [ACC_W-1:0] sum;

   always_comb begin
      off_ext = ACC_W'($signed(offset));
      sum     = off_ext;
      term    = '0;
      for (int j = 0; j < N_COORD; j++) begin
         term = ACC_W'($signed(coords[j*COORD_W +: COORD_W])) *
                ACC_W'($signed(coefs[j*CONST_W +: CONST_W]));
         if (mask[j])
            sum = sum + term;
      end
   end

   always_ff @(posedge clk) begin
      acc_q <= sum;
   end

   // With no coordinate present the row must reduce to its offset.
   assert_masked_row_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && mask == '0) |=> acc_q == $past(off_ext));

endmodule

// File: rtl/ltf_chi2.sv
module ltf_chi2 #(
   parameter int N_CON     = 9,
   parameter int ACC_W     = 20,
   parameter int CHI_W     = 44,
   parameter int CHI_LIMIT = 36
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      vld,
   input  logic [N_CON*ACC_W-1:0]    con,
   output logic [CHI_W-1:0]          chi2_q,
   output logic                      pass_q
);

   logic signed [2*ACC_W-1:0] sq;
   logic [CHI_W-1:0]          total;

   always_comb begin
      total = '0;
      sq    = '0;
      for (int k = 0; k < N_CON; k++) begin
         sq    = (2*ACC_W)'($signed(con[k*ACC_W +: ACC_W])) *
                 (2*ACC_W)'($signed(con[k*ACC_W +: ACC_W]));
         total = total + CHI_W'($unsigned(sq));
      end
   end

   always_ff @(posedge clk) begin
      chi2_q <= total;
      pass_q <= total < CHI_W'(CHI_LIMIT);
   end

   // Zero residuals give zero chi-square and an accepted track.
   assert_zero_residual_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && con == '0) |=> (chi2_q == '0 && pass_q));

endmodule

// File: rtl/linear_track_fitter.sv
module linear_track_fitter
   import ltf_pkg::*;
#(
   parameter int  N_SECT  = 4,
   parameter int  N_COORD = 14,
   parameter int  N_PAR   = 5,
   parameter int  N_CON   = 9,
   parameter int  COORD_W = 8,
   parameter int  CONST_W = 8,
   parameter int  TAG_W   = 8,
   parameter int  CHI_CUT = 4,
   parameter bit  MASK_EN = 1'b1,
   localparam int N_OUT   = N_PAR + N_CON,
   localparam int N_COL   = N_COORD + 1,
   localparam int SECT_W  = $clog2(N_SECT),
   localparam int ROW_W   = $clog2(N_OUT),
   localparam int COL_W   = $clog2(N_COL),
   localparam int ACC_W   = row_width(COORD_W, CONST_W, N_COL),
   localparam int CHI_W   = chi_width(ACC_W, N_CON)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        in_valid,
   input  logic [N_COORD*COORD_W-1:0]  in_coord,
   input  logic [N_COORD-1:0]          in_mask,
   input  logic [SECT_W-1:0]           in_sector,
   input  logic [TAG_W-1:0]            in_tag,
   input  logic                        cfg_we,
   input  logic [SECT_W-1:0]           cfg_sector,
   input  logic [ROW_W-1:0]            cfg_row,
   input  logic [COL_W-1:0]            cfg_col,
   input  logic [CONST_W-1:0]          cfg_data,
   output logic                        out_valid,
   output logic [TAG_W-1:0]            out_tag,
   output logic [N_PAR*ACC_W-1:0]      out_par,
   output logic [CHI_W-1:0]            out_chi2,
   output logic                        out_pass
);

   localparam int CHI_LIMIT = CHI_CUT * N_CON;

   // Elaboration-time parameter checks.
   if (N_SECT < 2)   begin : g_bad_sect  $error("N_SECT must be at least 2"); end
   if (N_PAR < 1)    begin : g_bad_par   $error("N_PAR must be at least 1"); end
   if (N_CON < 1)    begin : g_bad_con   $error("N_CON must be at least 1"); end
   if (COORD_W < 2)  begin : g_bad_cw    $error("COORD_W must be at least 2"); end
   if (CONST_W < 2)  begin : g_bad_kw    $error("CONST_W must be at least 2"); end
   if (CHI_CUT < 1)  begin : g_bad_cut   $error("CHI_CUT must be at least 1"); end
   if (N_COORD < 1)  begin : g_bad_coord $error("N_COORD must be at least 1"); end

   // Stage 0: capture of the candidate.
   logic                       s0_valid;
   logic [N_COORD*COORD_W-1:0] s0_coord;
   logic [N_COORD-1:0]         s0_mask;
   logic [SECT_W-1:0]          s0_sector;
   logic [TAG_W-1:0]           s0_tag;
   logic [N_COORD-1:0]         eff_mask;

   if (MASK_EN) begin : g_mask_on
      assign eff_mask = in_mask;
   end else begin : g_mask_off
      assign eff_mask = '1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) s0_valid <= 1'b0;
      else        s0_valid <= in_valid;
   end

   always_ff @(posedge clk) begin
      s0_coord  <= in_coord;
      s0_mask   <= eff_mask;
      s0_sector <= in_sector;
      s0_tag    <= in_tag;
   end

   // Constant tables, read by the sector of the candidate in stage 0.
   logic [N_OUT*N_COL*CONST_W-1:0] table_row;

   ltf_const_store #(
      .N_SECT(N_SECT), .N_OUT(N_OUT), .N_COL(N_COL), .CONST_W(CONST_W),
      .SECT_W(SECT_W), .ROW_W(ROW_W), .COL_W(COL_W)
   ) const_store_i (
      .clk       (clk),
      .wr_en     (cfg_we),
      .wr_sector (cfg_sector),
      .wr_row    (cfg_row),
      .wr_col    (cfg_col),
      .wr_data   (cfg_data),
      .rd_sector (s0_sector),
      .rd_table  (table_row)
   );

   // Stage 1: one multiply-accumulate row per output.
   logic signed [ACC_W-1:0] row_q [N_OUT];
   logic [N_CON*ACC_W-1:0]  con_flat;
   logic                    s1_valid;
   logic [TAG_W-1:0]        s1_tag;

   for (genvar r = 0; r < N_OUT; r++) begin : g_dot
      ltf_dot_row #(
         .N_COORD(N_COORD), .COORD_W(COORD_W), .CONST_W(CONST_W), .ACC_W(ACC_W)
      ) dot_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .vld    (s0_valid),
         .coords (s0_coord),
         .mask   (s0_mask),
         .coefs  (table_row[r*N_COL*CONST_W +: N_COORD*CONST_W]),
         .offset (table_row[(r*N_COL + N_COORD)*CONST_W +: CONST_W]),
         .acc_q  (row_q[r])
      );
   end

   for (genvar k = 0; k < N_CON; k++) begin : g_con
      assign con_flat[k*ACC_W +: ACC_W] = row_q[N_PAR + k];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) s1_valid <= 1'b0;
      else        s1_valid <= s0_valid;
   end

   always_ff @(posedge clk) begin
      s1_tag <= s0_tag;
   end

   // Stage 2: chi-square, cut and output registers.
   ltf_chi2 #(
      .N_CON(N_CON), .ACC_W(ACC_W), .CHI_W(CHI_W), .CHI_LIMIT(CHI_LIMIT)
   ) chi2_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .vld    (s1_valid),
      .con    (con_flat),
      .chi2_q (out_chi2),
      .pass_q (out_pass)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_valid <= 1'b0;
      else        out_valid <= s1_valid;
   end

   always_ff @(posedge clk) begin
      out_tag <= s1_tag;
      for (int p = 0; p < N_PAR; p++)
         out_par[p*ACC_W +: ACC_W] <= row_q[p];
   end

   // Pipeline behaviour checks.
   assert_idle_in_reset_R1: assert property (@(posedge clk)
      !rst_n |-> !out_valid);

   assert_stage_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
      s0_valid |=> s1_valid);

   assert_no_phantom_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !s1_valid |=> !out_valid);

   assert_tag_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid |=> (out_valid && out_tag == $past(s1_tag)));

endmodule

// File: tb/linear_track_fitter_tb.sv
module linear_track_fitter_tb_top;

   localparam int N_SECT  = 4;
   localparam int N_COORD = 14;
   localparam int N_PAR   = 5;
   localparam int N_CON   = 9;
   localparam int N_OUT   = 14;
   localparam int N_COL   = 15;
   localparam int COORD_W = 8;
   localparam int CONST_W = 8;
   localparam int TAG_W   = 8;
   localparam int ACC_W   = 20;
   localparam int CHI_W   = 44;
   localparam int LIMIT   = 36;

   logic                       clk;
   logic                       rst_n;
   logic                       in_valid;
   logic [N_COORD*COORD_W-1:0] in_coord;
   logic [N_COORD-1:0]         in_mask;
   logic [1:0]                 in_sector;
   logic [TAG_W-1:0]           in_tag;
   logic                       cfg_we;
   logic [1:0]                 cfg_sector;
   logic [3:0]                 cfg_row;
   logic [3:0]                 cfg_col;
   logic [CONST_W-1:0]         cfg_data;
   logic                       out_valid;
   logic [TAG_W-1:0]           out_tag;
   logic [N_PAR*ACC_W-1:0]     out_par;
   logic [CHI_W-1:0]           out_chi2;
   logic                       out_pass;

   linear_track_fitter dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_coord(in_coord),
      .in_mask(in_mask), .in_sector(in_sector), .in_tag(in_tag),
      .cfg_we(cfg_we), .cfg_sector(cfg_sector), .cfg_row(cfg_row),
      .cfg_col(cfg_col), .cfg_data(cfg_data), .out_valid(out_valid),
      .out_tag(out_tag), .out_par(out_par), .out_chi2(out_chi2),
      .out_pass(out_pass)
   );

   initial clk = 1'b0;
   always #4 clk = ~clk;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   string phase = "R1";
   bit [31:0] lf = 32'h1234_5678;

   int cst [N_SECT][N_OUT][N_COL];
   int cv [N_COORD];

   typedef struct {
      longint par [N_PAR];
      longint chi2;
      bit     pass;
      int     tag;
      int     cyc;
   } exp_t;
   exp_t q [$];

   always @(posedge clk) cyc++;

   task automatic chk(string req, string what, longint act, longint expv);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   function automatic int rnd();
      lf ^= lf << 13;
      lf ^= lf >> 17;
      lf ^= lf << 5;
      return int'(lf);
   endfunction

   function automatic int rnd8();
      bit [31:0] v;
      v = rnd();
      return int'($signed(v[7:0]));
   endfunction

   task automatic wr(int s, int r, int c, int v);
      @(negedge clk);
      cfg_we     = 1'b1;
      cfg_sector = 2'(s);
      cfg_row    = 4'(r);
      cfg_col    = 4'(c);
      cfg_data   = 8'(v);
      cst[s][r][c] = v;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // Drives one candidate from cv and queues its expected result.
   task automatic issue(bit [N_COORD-1:0] m, int s, int tag);
      exp_t e;
      longint acc;
      @(negedge clk);
      in_valid  = 1'b1;
      in_mask   = m;
      in_sector = 2'(s);
      in_tag    = 8'(tag);
      for (int j = 0; j < N_COORD; j++)
         in_coord[j*COORD_W +: COORD_W] = 8'(cv[j]);
      e.chi2 = 0;
      for (int r = 0; r < N_OUT; r++) begin
         acc = cst[s][r][N_COORD];
         for (int j = 0; j < N_COORD; j++)
            if (m[j]) acc += longint'(cv[j]) * longint'(cst[s][r][j]);
         if (r < N_PAR) e.par[r] = acc;
         else           e.chi2 += acc * acc;
      end
      e.pass = e.chi2 < LIMIT;
      e.tag  = tag & 255;
      e.cyc  = cyc;
      q.push_back(e);
   endtask

   task automatic idle_drain();
      @(negedge clk);
      in_valid = 1'b0;
      repeat (5) @(negedge clk);
   endtask

   // Result monitor: compares every emerging result with the queued one.
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (q.size() == 0) begin
            chk("R7", "unexpected result", 1, 0);
         end else begin
            exp_t e;
            e = q.pop_front();
            for (int p = 0; p < N_PAR; p++)
               chk({phase, " R2"}, $sformatf("par%0d", p),
                   longint'($signed(out_par[p*ACC_W +: ACC_W])), e.par[p]);
            chk({phase, " R3"}, "chi2", longint'(out_chi2), e.chi2);
            chk({phase, " R4"}, "pass", longint'(out_pass), longint'(e.pass));
            chk({phase, " R8"}, "tag", longint'(out_tag), longint'(e.tag));
            chk({phase, " R7"}, "latency", longint'(cyc - e.cyc), 3);
         end
      end
   end

   initial begin
      #(8 * 150000);
      chk("watchdog", "timeout", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; in_coord = '0; in_mask = '0;
      in_sector = '0; in_tag = '0; cfg_we = 1'b0; cfg_sector = '0;
      cfg_row = '0; cfg_col = '0; cfg_data = '0;
      repeat (3) @(negedge clk);
      chk("R1", "out_valid in reset", longint'(out_valid), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1", "out_valid idle after reset", longint'(out_valid), 0);

      // R9: load every sector with pseudo-random constants.
      for (int s = 0; s < N_SECT; s++)
         for (int r = 0; r < N_OUT; r++)
            for (int c = 0; c < N_COL; c++)
               wr(s, r, c, rnd8());

      // R5 R6 R7: back-to-back random stream with random masks and sectors.
      phase = "R5 R6 R7 stream";
      for (int i = 0; i < 200; i++) begin
         for (int j = 0; j < N_COORD; j++) cv[j] = rnd8();
         issue(14'(rnd()), rnd() & 3, i);
      end
      idle_drain();

      // R6: no coordinate present gives the offsets.
      phase = "R6 empty mask";
      for (int s = 0; s < N_SECT; s++) begin
         for (int j = 0; j < N_COORD; j++) cv[j] = rnd8();
         issue('0, s, 40 + s);
      end
      idle_drain();

      // R5: each sector, each coordinate alone set to 1.
      phase = "R5 unit sweep";
      for (int s = 0; s < N_SECT; s++)
         for (int j = 0; j < N_COORD; j++) begin
            for (int k = 0; k < N_COORD; k++) cv[k] = (k == j) ? 1 : 0;
            issue('1, s, s * 16 + j);
         end
      idle_drain();

      // R10: extreme codes everywhere in sector 2.
      phase = "R10 extremes";
      for (int r = 0; r < N_OUT; r++)
         for (int c = 0; c < N_COL; c++) wr(2, r, c, -128);
      for (int j = 0; j < N_COORD; j++) cv[j] = -128;
      issue('1, 2, 200);
      for (int j = 0; j < N_COORD; j++) cv[j] = 127;
      issue('1, 2, 201);
      idle_drain();
      for (int r = 0; r < N_OUT; r++)
         for (int c = 0; c < N_COL; c++) wr(2, r, c, 127);
      for (int j = 0; j < N_COORD; j++) cv[j] = -128;
      issue('1, 2, 202);
      idle_drain();

      // R4 R9: chi-square cut boundary through constraint offsets of sector 3.
      phase = "R4 R9 cut";
      for (int r = N_PAR; r < N_OUT; r++)
         for (int c = 0; c < N_COORD; c++) wr(3, r, c, 0);
      for (int j = 0; j < N_COORD; j++) cv[j] = rnd8();
      for (int t = 0; t < 7; t++) begin
         int offs [N_CON];
         for (int k = 0; k < N_CON; k++) offs[k] = 0;
         case (t)
            0: offs[0] = 6;
            1: begin offs[0] = 5; offs[1] = 3; offs[2] = 1; end
            2: begin offs[3] = 4; offs[4] = 4; offs[5] = 2; end
            3: ;
            4: for (int k = 0; k < N_CON; k++) offs[k] = 1;
            5: offs[8] = -6;
            default: begin offs[6] = -5; offs[7] = -3; offs[8] = -1; end
         endcase
         for (int k = 0; k < N_CON; k++) wr(3, N_PAR + k, N_COORD, offs[k]);
         issue('1, 3, 100 + t);
         idle_drain();
      end

      chk("R7", "results left in flight", longint'(q.size()), 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule